// File: doc/BRIEF.md
# Synchronous FIFO write master

This block drives the write side of a synchronous slave FIFO from the master's end. Words come in on a ready/valid stream that carries a last-word marker and an empty-data marker. The block turns them into the slave's signals: a port address, an active-low chip-select, an active-low write strobe, an active-low end-of-packet strobe and a data bus. Each transaction follows a fixed order. The block latches the address and drops chip-select, waits one idle setup cycle, and then writes one word per clock for as long as the source and the flow control allow.

The slave's active-low full flag reacts to writes only after a fixed number of cycles. The block therefore keeps a short record of the writes it has issued recently. It stops accepting words once that count reaches a programmable watermark, which is the number of free words the slave promises to hold whenever it shows not-full. When a packet ends, the last word carries the end-of-packet strobe. A beat that is both last and empty produces a zero-length packet marker: the end-of-packet strobe falls while the write strobe stays high. Chip-select then stays low for a programmable number of hold cycles. A new beat for the same address during that time continues the session without a fresh setup.

Top module: `sfifo_wr_master`

## Requirements
- R1: Every fall of `cs_n` is followed by at least one cycle in which `cs_n` is low and both `wr_n` and `pktend_n` are high. `fifo_addr` takes the value of `cfg_addr` as `cs_n` falls. No strobe and no `s_ready` occur while `cs_n` is high.
- R2: `fifo_addr` does not change during any cycle in which `cs_n` stays low, even if `cfg_addr` changes.
- R3: A non-empty beat accepted at a clock edge appears as exactly one cycle of `wr_n` low after that edge, with `fifo_data` equal to the beat's data. Words leave in acceptance order.
- R4: With `full_n` high, `cfg_wm` greater than `FLAG_LAT` and a continuously valid source, the words of a packet go out on consecutive cycles, one per cycle, with `wr_n` and `cs_n` held low.
- R5: With `SHORT_PKT_EN`=1, the cycle that carries the write of a beat with `s_last`=1 also has `pktend_n` low. `pktend_n` is low in no other write cycle.
- R6: A beat with `s_last`=1 and `s_empty`=1 produces one cycle with `pktend_n` low, `wr_n` high and `cs_n` low, and no write. A beat with `s_empty`=1 and `s_last`=0 is consumed with no strobe.
- R7: A beat is accepted only while `full_n` is high and fewer than `cfg_wm` words were written in the previous `FLAG_LAT` cycles. A slave that shows not-full only with at least `cfg_wm` free words is therefore never overrun. With `cfg_wm`=1, two writes are at least `FLAG_LAT`+1 cycles apart.
- R8: After the cycle that carries a packet's final strobe, `cs_n` stays low for exactly `cfg_hold` cycles and then rises. A valid beat for the same `cfg_addr` that arrives in that window continues the session with no rise of `cs_n`. A beat for a different address waits for the rise and a new setup.
- R9: With `SHORT_PKT_EN`=0, `pktend_n` stays high. Empty beats are consumed with no strobe.
- R10: During reset `cs_n`, `wr_n` and `pktend_n` are high and `s_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | ADDR_W | Slave port address for the next session |
| cfg_wm | input | WM_W | Words the slave guarantees free while not-full |
| cfg_hold | input | HOLD_W | Chip-select hold cycles after a packet |
| s_valid | input | 1 | Source beat valid |
| s_ready | output | 1 | Beat accepted at this edge when valid |
| s_data | input | DATA_W | Source word |
| s_last | input | 1 | Beat closes the packet |
| s_empty | input | 1 | Beat carries no data |
| full_n | input | 1 | Slave flag, low when full, delayed by FLAG_LAT |
| fifo_addr | output | ADDR_W | Slave port address |
| cs_n | output | 1 | Chip-select, active low |
| wr_n | output | 1 | Write strobe, active low |
| pktend_n | output | 1 | End-of-packet strobe, active low |
| fifo_data | output | DATA_W | Write data bus |

## Verification
The bench sweeps every hold count, address and packet length from one to four words. For each packet it measures the chip-select gap after the final strobe, the run length of the writes and the position of the end-of-packet strobe. An off-by-one in the hold counter shows up as a wrong gap, a missing setup cycle shows up as a strobe at the fall of chip-select, and an end-of-packet on the wrong word shows up as mismatched data. A bench model of an eight-word slave, with the same flag delay and without draining, runs under every watermark from one to four. A design that trusted the late flag alone would overrun it, and a design that ignored the watermark would break the spacing rule at a watermark of one. Zero-length beats, empty non-last beats, resumption during hold, an address change during hold and the variant without end-of-packet are each tested on their own.

// File: rtl/sfifo_wr_pkg.sv
package sfifo_wr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_ACTIVE = 2'd2,
      ST_HOLD   = 2'd3
   } wr_state_t;

   localparam int unsigned MAX_FLAG_LAT = 16;

endpackage

// File: rtl/sfifo_wr_credit.sv
module sfifo_wr_credit #(
   parameter int unsigned FLAG_LAT = 3,
   parameter int unsigned WM_W     = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_issue,
   input  logic            full_n,
   input  logic [WM_W-1:0] cfg_wm,
   output logic            can_write
);

   localparam int unsigned CNT_W = $clog2(FLAG_LAT + 1);
   localparam int unsigned CMP_W = (CNT_W > WM_W) ? CNT_W : WM_W;

   logic [FLAG_LAT-1:0] hist;
   logic [CNT_W-1:0]    inflight;
   logic [CMP_W-1:0]    inflight_x;
   logic [CMP_W-1:0]    wm_x;

   // history of writes the slave flag cannot have seen yet
   generate
      if (FLAG_LAT == 1) begin : g_hist_one
         always_ff @(posedge clk) begin
            if (!rst_n) hist <= '0;
            else        hist <= wr_issue;
         end
      end else begin : g_hist_shift
         always_ff @(posedge clk) begin
            if (!rst_n) hist <= '0;
            else        hist <= {hist[FLAG_LAT-2:0], wr_issue};
         end
      end
   endgenerate

   always_comb begin
      inflight   = CNT_W'($countones(hist));
      inflight_x = CMP_W'(inflight);
      wm_x       = CMP_W'(cfg_wm);
      can_write  = full_n && (inflight_x < wm_x);
   end

endmodule

// File: rtl/sfifo_wr_seq.sv
module sfifo_wr_seq
   import sfifo_wr_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned HOLD_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [HOLD_W-1:0] cfg_hold,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_last,
   input  logic              s_empty,
   input  logic              can_write,
   output logic              wr_issue,
   output logic [ADDR_W-1:0] addr_q,
   output logic              cs_n_q,
   output logic              wr_n_q,
   output logic              eop_n_q,
   output logic [DATA_W-1:0] data_q
);

   wr_state_t         st;
   logic [HOLD_W-1:0] hold_cnt;
   logic              accept;
   logic              same_port;

   always_comb begin
      s_ready   = (st == ST_ACTIVE) && can_write;
      accept    = s_valid && s_ready;
      wr_issue  = accept && !s_empty;
      same_port = (cfg_addr == addr_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         hold_cnt <= '0;
         addr_q   <= '0;
         cs_n_q   <= 1'b1;
         wr_n_q   <= 1'b1;
         eop_n_q  <= 1'b1;
         data_q   <= '0;
      end else begin
         wr_n_q  <= 1'b1;
         eop_n_q <= 1'b1;
         unique case (st)
            ST_IDLE: begin
               if (s_valid) begin
                  addr_q <= cfg_addr;
                  cs_n_q <= 1'b0;
                  st     <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               st <= ST_ACTIVE;
            end
            ST_ACTIVE: begin
               if (accept) begin
                  wr_n_q  <= s_empty;
                  eop_n_q <= !s_last;
                  if (!s_empty) data_q <= s_data;
                  if (s_last) begin
                     st       <= ST_HOLD;
                     hold_cnt <= cfg_hold;
                  end
               end
            end
            ST_HOLD: begin
               if (s_valid && same_port) begin
                  st <= ST_ACTIVE;
               end else if (hold_cnt == '0) begin
                  cs_n_q <= 1'b1;
                  st     <= ST_IDLE;
               end else begin
                  hold_cnt <= hold_cnt - 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sfifo_wr_master.sv
module sfifo_wr_master
   import sfifo_wr_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned ADDR_W       = 2,
   parameter int unsigned FLAG_LAT     = 3,
   parameter int unsigned WM_W         = 3,
   parameter int unsigned HOLD_W       = 3,
   parameter int unsigned SHORT_PKT_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [WM_W-1:0]   cfg_wm,
   input  logic [HOLD_W-1:0] cfg_hold,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_last,
   input  logic              s_empty,
   input  logic              full_n,
   output logic [ADDR_W-1:0] fifo_addr,
   output logic              cs_n,
   output logic              wr_n,
   output logic              pktend_n,
   output logic [DATA_W-1:0] fifo_data
);

   initial begin
      if (FLAG_LAT < 1 || FLAG_LAT > MAX_FLAG_LAT)
         $fatal(1, "FLAG_LAT out of range");
      if (DATA_W < 1 || ADDR_W < 1 || WM_W < 1 || HOLD_W < 1)
         $fatal(1, "widths must be positive");
      if (SHORT_PKT_EN > 1)
         $fatal(1, "SHORT_PKT_EN must be 0 or 1");
   end

   logic can_write;
   logic wr_issue;
   logic eop_n_q;

   sfifo_wr_credit #(
      .FLAG_LAT (FLAG_LAT),
      .WM_W     (WM_W)
   ) u_credit (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_issue  (wr_issue),
      .full_n    (full_n),
      .cfg_wm    (cfg_wm),
      .can_write (can_write)
   );

   sfifo_wr_seq #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .HOLD_W (HOLD_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_addr  (cfg_addr),
      .cfg_hold  (cfg_hold),
      .s_valid   (s_valid),
      .s_ready   (s_ready),
      .s_data    (s_data),
      .s_last    (s_last),
      .s_empty   (s_empty),
      .can_write (can_write),
      .wr_issue  (wr_issue),
      .addr_q    (fifo_addr),
      .cs_n_q    (cs_n),
      .wr_n_q    (wr_n),
      .eop_n_q   (eop_n_q),
      .data_q    (fifo_data)
   );

   // variant select: end-of-packet strobe driven or tied inactive
   generate
      if (SHORT_PKT_EN != 0) begin : g_eop
         assign pktend_n = eop_n_q;
      end else begin : g_no_eop
         assign pktend_n = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/sfifo_wr_master_chk.sv
module sfifo_wr_master_chk #(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned PKT_EN = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_valid,
   input logic              s_ready,
   input logic              s_last,
   input logic              s_empty,
   input logic              full_n,
   input logic [ADDR_W-1:0] fifo_addr,
   input logic              cs_n,
   input logic              wr_n,
   input logic              pktend_n
);

   p_setup_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (wr_n && pktend_n));

   p_strobe_selected_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n || !pktend_n) |-> !cs_n);

   p_ready_selected_r1: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> !cs_n);

   p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !$past(cs_n)) |-> (fifo_addr == $past(fifo_addr)));

   p_word_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready && !s_empty) |=> !wr_n);

   p_zlp_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (PKT_EN != 0 && s_valid && s_ready && s_last && s_empty) |=> (wr_n && !pktend_n));

   p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> !s_ready);

endmodule

bind sfifo_wr_master sfifo_wr_master_chk #(
   .ADDR_W (ADDR_W),
   .PKT_EN (SHORT_PKT_EN)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .s_valid   (s_valid),
   .s_ready   (s_ready),
   .s_last    (s_last),
   .s_empty   (s_empty),
   .full_n    (full_n),
   .fifo_addr (fifo_addr),
   .cs_n      (cs_n),
   .wr_n      (wr_n),
   .pktend_n  (pktend_n)
);

// File: tb/test_sfifo_wr_master.sv
module test_sfifo_wr_master;

   localparam int DW    = 16;
   localparam int AW    = 2;
   localparam int LAT   = 3;
   localparam int WMW   = 3;
   localparam int HW    = 3;
   localparam int DEPTH = 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [WMW-1:0] cfg_wm = 3'd4;
   logic [HW-1:0] cfg_hold = '0;
   logic          s_valid = 1'b0, s_last = 1'b0, s_empty = 1'b0;
   logic [DW-1:0] s_data = '0;
   logic          s_ready;
   logic          full_n = 1'b1;
   logic [AW-1:0] fifo_addr;
   logic          cs_n, wr_n, pktend_n;
   logic [DW-1:0] fifo_data;

   logic          b_valid = 1'b0, b_last = 1'b0, b_empty = 1'b0;
   logic [DW-1:0] b_data = '0;
   logic          b_ready, b_cs_n, b_wr_n, b_pktend_n;
   logic [AW-1:0] b_addr;
   logic [DW-1:0] b_fdata;

   sfifo_wr_master #(.DATA_W(DW), .ADDR_W(AW), .FLAG_LAT(LAT), .WM_W(WMW),
                     .HOLD_W(HW), .SHORT_PKT_EN(1)) i_sfifo_wr_master (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wm(cfg_wm),
      .cfg_hold(cfg_hold), .s_valid(s_valid), .s_ready(s_ready),
      .s_data(s_data), .s_last(s_last), .s_empty(s_empty), .full_n(full_n),
      .fifo_addr(fifo_addr), .cs_n(cs_n), .wr_n(wr_n), .pktend_n(pktend_n),
      .fifo_data(fifo_data));

   sfifo_wr_master #(.DATA_W(DW), .ADDR_W(AW), .FLAG_LAT(LAT), .WM_W(WMW),
                     .HOLD_W(HW), .SHORT_PKT_EN(0)) i_sfifo_wr_master_b (
      .clk(clk), .rst_n(rst_n), .cfg_addr(2'd0), .cfg_wm(3'd4),
      .cfg_hold(3'd1), .s_valid(b_valid), .s_ready(b_ready),
      .s_data(b_data), .s_last(b_last), .s_empty(b_empty), .full_n(1'b1),
      .fifo_addr(b_addr), .cs_n(b_cs_n), .wr_n(b_wr_n), .pktend_n(b_pktend_n),
      .fifo_data(b_fdata));

   int tests = 0, fails = 0;

   // slave model and monitor state
   int cyc = 0, fill = 0, drain = 1;
   logic [LAT-1:0] fpipe = '1;
   logic [DW-1:0] expq[$];
   int n_wr, n_eop, n_eop_wr, n_eop_zlp, setup_bad, addr_bad, data_bad;
   int cs_rises, cs_falls, fall_addr, gap_last, last_strobe, last_wr;
   int min_gap, run_cur, run_max, overflow, max_fill, b_wr, b_eop;
   logic [DW-1:0] eop_data;
   logic prev_cs_n = 1'b1;
   logic [AW-1:0] prev_addr = '0;

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clr();
      n_wr = 0; n_eop = 0; n_eop_wr = 0; n_eop_zlp = 0; setup_bad = 0;
      addr_bad = 0; data_bad = 0; cs_rises = 0; cs_falls = 0; fall_addr = -1;
      gap_last = -1; min_gap = 1000; run_cur = 0; run_max = 0; overflow = 0;
      max_fill = 0; b_wr = 0; b_eop = 0; eop_data = '0;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (!cs_n && prev_cs_n) begin
            cs_falls++;
            fall_addr = int'(fifo_addr);
            if (!(wr_n && pktend_n)) setup_bad++;
         end
         if (cs_n && !prev_cs_n) begin
            cs_rises++;
            gap_last = cyc - last_strobe - 1;
         end
         if (!cs_n && !prev_cs_n && fifo_addr != prev_addr) addr_bad++;
         if (!wr_n) begin
            n_wr++;
            if (expq.size() == 0) data_bad++;
            else if (expq.pop_front() != fifo_data) data_bad++;
            fill++;
            if (fill > DEPTH) overflow++;
            if (fill > max_fill) max_fill = fill;
            if (n_wr > 1 && (cyc - last_wr) < min_gap) min_gap = cyc - last_wr;
            last_wr = cyc;
            run_cur++;
            if (run_cur > run_max) run_max = run_cur;
         end else begin
            run_cur = 0;
         end
         if (!pktend_n) begin
            n_eop++;
            if (!wr_n) begin n_eop_wr++; eop_data = fifo_data; end
            else n_eop_zlp++;
         end
         if (!wr_n || !pktend_n) last_strobe = cyc;
         if (drain != 0 && fill > 0) fill--;
         fpipe = {fpipe[LAT-2:0], ((DEPTH - fill) >= int'(cfg_wm))};
         full_n = fpipe[LAT-1];
         prev_cs_n = cs_n;
         prev_addr = fifo_addr;
         if (!b_wr_n) b_wr++;
         if (!b_pktend_n) b_eop++;
      end
   end

   // call at a falling edge; returns at the falling edge after acceptance
   task automatic send(input logic [DW-1:0] d, input logic last, input logic emp);
      bit done = 0;
      s_valid = 1'b1; s_data = d; s_last = last; s_empty = emp;
      while (!done) begin
         #3;
         done = s_ready;
         if (done && !emp) expq.push_back(d);
         @(negedge clk);
      end
      s_valid = 1'b0; s_last = 1'b0; s_empty = 1'b0;
   endtask

   task automatic send_b(input logic [DW-1:0] d, input logic last, input logic emp);
      bit done = 0;
      b_valid = 1'b1; b_data = d; b_last = last; b_empty = emp;
      while (!done) begin
         #3;
         done = b_ready;
         @(negedge clk);
      end
      b_valid = 1'b0; b_last = 1'b0; b_empty = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (2) @(negedge clk);
      while (!cs_n || !b_cs_n) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: run hung, actual 1 expected 0");
      summary();
      $finish;
   end

   initial begin
      clr();
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 cs_n in reset", int'(cs_n), 1);
      chk("R10 wr_n in reset", int'(wr_n), 1);
      chk("R10 pktend_n in reset", int'(pktend_n), 1);
      chk("R10 s_ready in reset", int'(s_ready), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // sweep hold x address x length with full rate flow control
      cfg_wm = 3'd4;
      for (int h = 0; h < 4; h++) begin
         for (int a = 0; a < 4; a++) begin
            for (int len = 1; len <= 4; len++) begin
               logic [DW-1:0] lastw;
               clr();
               cfg_hold = HW'(h);
               cfg_addr = AW'(a);
               for (int i = 0; i < len; i++) begin
                  lastw = DW'((h << 12) | (a << 8) | (len << 4) | i);
                  send(lastw, (i == len - 1), 1'b0);
               end
               wait_idle();
               chk("R1 setup cycle before strobe", setup_bad, 0);
               chk("R1 address latched at select", fall_addr, a);
               chk("R2 address stable while selected", addr_bad, 0);
               chk("R3 word count", n_wr, len);
               chk("R3 data order", data_bad, 0);
               chk("R4 back-to-back run", run_max, len);
               chk("R5 one end strobe on a write", n_eop_wr * 10 + n_eop, 11);
               chk("R5 end strobe on last word", int'(eop_data), int'(lastw));
               chk("R8 hold gap", gap_last, h);
            end
         end
      end

      // R6 zero-length packet
      clr(); cfg_hold = 3'd1; cfg_addr = 2'd2;
      send(16'h0, 1'b1, 1'b1);
      wait_idle();
      chk("R6 zlp end strobe without write", n_eop_zlp, 1);
      chk("R6 zlp no write", n_wr, 0);
      chk("R6 zlp setup", setup_bad, 0);

      // R6 empty beat without last is dropped
      clr();
      send(16'h1111, 1'b0, 1'b1);
      send(16'hABCD, 1'b1, 1'b0);
      wait_idle();
      chk("R6 empty non-last adds no strobe", n_wr * 10 + n_eop, 11);
      chk("R6 following word data", int'(eop_data), 16'hABCD);

      // R8 resume during hold on same address
      clr(); cfg_hold = 3'd3; cfg_addr = 2'd1;
      send(16'h0101, 1'b0, 1'b0); send(16'h0102, 1'b1, 1'b0);
      send(16'h0103, 1'b0, 1'b0); send(16'h0104, 1'b1, 1'b0);
      wait_idle();
      chk("R8 resume keeps select low", cs_falls * 10 + cs_rises, 11);
      chk("R8 resume words", n_wr, 4);
      chk("R8 resume end strobes", n_eop, 2);

      // R8 / R2 address change during hold
      clr(); cfg_hold = 3'd3; cfg_addr = 2'd1;
      send(16'h0201, 1'b1, 1'b0);
      cfg_addr = 2'd2;
      send(16'h0202, 1'b1, 1'b0);
      wait_idle();
      chk("R8 new address reselects", cs_falls, 2);
      chk("R8 new address used", fall_addr, 2);
      chk("R2 no address change while selected", addr_bad, 0);
      chk("R1 setup on each select", setup_bad, 0);

      // R7 throttling against a non-draining slave
      for (int wm = 1; wm <= 4; wm++) begin
         cfg_wm = WMW'(wm); cfg_hold = 3'd0; cfg_addr = 2'd3;
         drain = 0; fill = 0; fpipe = '1;
         repeat (LAT + 2) @(negedge clk);
         clr();
         fork
            begin
               for (int i = 0; i < 12; i++) send(DW'(16'h3000 + i), (i == 11), 1'b0);
            end
            begin
               repeat (40) @(negedge clk);
               chk("R7 no overrun while stalled", overflow, 0);
               chk("R7 stalled before all words", int'(n_wr < 12), 1);
               drain = 1;
            end
         join
         wait_idle();
         chk("R7 no overrun", overflow, 0);
         chk("R7 all words delivered", n_wr, 12);
         chk("R7 data order", data_bad, 0);
         if (wm == 1) chk("R7 spacing at watermark one", min_gap, LAT + 1);
         if (wm == 4) chk("R4 full rate above flag delay", min_gap, 1);
      end
      cfg_wm = 3'd4;

      // R9 variant without end-of-packet strobe
      clr();
      send_b(16'h0, 1'b1, 1'b1);
      send_b(16'h5555, 1'b1, 1'b0);
      wait_idle();
      chk("R9 end strobe tied high", b_eop, 0);
      chk("R9 empty beat writes nothing", b_wr, 1);

      summary();
      $finish;
   end

endmodule